// File: doc/BRIEF.md
# Protection Region Checker

This block sits beside a 32-bit address path and decides, for every access, whether it may proceed. It holds a small set of programmable protection regions. Each region is a power-of-two block, from 32 bytes up to the whole 4 GB space, placed on a boundary that matches its size. Each region has an enable bit and a two-bit permission code. Software-side setup logic loads the regions through a simple write port. A separate control write sets a background bit that lets privileged accesses outside every region succeed.

For each access, the block takes the address, a write flag and a privilege flag. One clock later it reports grant or fault, the region that decided the result, a cause code, and the faulting address. Regions may overlap. When they do, the matching region with the highest index decides. An access that lands in no enabled region is a no-match fault. An access that lands in a region but breaks its permissions is a permission fault.

Top module: `mpu_region_check`

## Requirements
- R1: After reset, all response outputs are zero, every region is disabled and the background bit is clear. A first access therefore faults with cause no-match (code 1).
- R2: A region with size code N (4..31) covers 2^(N+1) bytes. Matching compares only the address bits above bit N, so the low bits of the written base are ignored. A size code below 4 disables the region.
- R3: Size code 31 covers the whole 4 GB space, whatever base is written.
- R4: When several enabled regions match, the highest-numbered one supplies the permissions and the reported region number.
- R5: Permission codes: 0 means no access. 1 means privileged read/write only. 2 means privileged read/write plus unprivileged read. 3 means full access.
- R6: The cause code is 0 on grant, 1 when no enabled region matches, and 2 on a permission violation. On a no-match, the region number and the hit flag are both 0.
- R7: With the background bit set, a privileged access that matches no region is granted with the hit flag low. An unprivileged access that matches no region still faults with no-match.
- R8: The response to an access appears on the clock edge that captures it and lasts one cycle. With no access, the response valid, grant and fault outputs are all low. On a fault, the fault address output equals the access address; otherwise it is zero.
- R9: A region write takes effect for the very next access. A region written with its enable bit clear never matches.
- R10: On a valid response, exactly one of grant and fault is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Region write strobe |
| cfg_sel | input | 3 | Index of the region being written |
| cfg_base | input | 32 | Region base address (low bits below the size ignored) |
| cfg_size | input | 5 | Size code N, region is 2^(N+1) bytes, N<4 disables |
| cfg_perm | input | 2 | Permission code |
| cfg_enable | input | 1 | Region enable |
| ctl_we | input | 1 | Control write strobe |
| ctl_bg_en | input | 1 | Privileged background enable value |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | 1 = privileged |
| rsp_valid | output | 1 | Response valid |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 2 | 0 none, 1 no match, 2 permission |
| rsp_hit | output | 1 | A region matched |
| rsp_region | output | 3 | Deciding region index |
| rsp_fault_addr | output | 32 | Faulting address, zero when granted |

## Verification
A corrupted region register leaves nothing wrong on the ports until an access falls inside the affected window. The next access there then shows a wrong region number, a wrong cause or a wrong grant, one cycle after it is presented. A fault in the priority logic shows only where regions overlap, so the stimulus places accesses on region bases with small offsets. This makes overlaps and edge addresses frequent. A wrong background bit shows only on privileged accesses that match no region, and the directed cases target exactly those.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int ADDR_W    = 32;
  localparam int SIZE_W    = 5;
  localparam int MIN_SIZE  = 4;

  typedef enum logic [1:0] {
    PERM_NONE  = 2'd0,
    PERM_PRIV  = 2'd1,
    PERM_URO   = 2'd2,
    PERM_FULL  = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_NOMATCH = 2'd1,
    CAUSE_PERM    = 2'd2
  } cause_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [SIZE_W-1:0] size;
    perm_e             perm;
    logic              en;
  } region_t;

  // Mask of address bits that take part in the comparison.
  function automatic logic [ADDR_W-1:0] region_mask(input logic [SIZE_W-1:0] size);
    logic [ADDR_W:0] ones;
    logic [SIZE_W:0] sh;
    ones = '1;
    sh   = {1'b0, size} + {{SIZE_W{1'b0}}, 1'b1};
    ones = ones << sh;
    return ones[ADDR_W-1:0];
  endfunction

  function automatic logic region_hit(input logic [ADDR_W-1:0] addr, input region_t r);
    logic [ADDR_W-1:0] m;
    m = region_mask(r.size);
    return r.en && (r.size >= SIZE_W'(MIN_SIZE)) && ((addr & m) == (r.base & m));
  endfunction

  function automatic logic perm_allows(input perm_e p, input logic wr, input logic priv);
    case (p)
      PERM_FULL: return 1'b1;
      PERM_URO:  return priv | ~wr;
      PERM_PRIV: return priv;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mpu_region_bank.sv
module mpu_region_bank
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = $clog2(NUM_REGIONS)
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        sel,
  input  region_t                 wdata,
  output region_t [NUM_REGIONS-1:0] regions
);
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regions[g] <= '0;
      else if (we && sel == IDX_W'(g))
        regions[g] <= wdata;
    end
  end
endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8
)(
  input  region_t [NUM_REGIONS-1:0] regions,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      wr,
  input  logic                      priv,
  output logic [NUM_REGIONS-1:0]    hit_vec,
  output logic [NUM_REGIONS-1:0]    allow_vec
);
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    assign hit_vec[g]   = region_hit(addr, regions[g]);
    assign allow_vec[g] = perm_allows(regions[g].perm, wr, priv);
  end
endmodule

// File: rtl/mpu_prio_select.sv
module mpu_prio_select #(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = $clog2(NUM_REGIONS)
)(
  input  logic [NUM_REGIONS-1:0] hit_vec,
  output logic                   any_hit,
  output logic [IDX_W-1:0]       win_idx
);
  // Higher index overrides lower one.
  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM_REGIONS; i++)
      if (hit_vec[i]) win_idx = IDX_W'(i);
  end
  assign any_hit = |hit_vec;
endmodule

// File: rtl/mpu_region_check.sv
module mpu_region_check
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = $clog2(NUM_REGIONS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_sel,
  input  logic [31:0]       cfg_base,
  input  logic [4:0]        cfg_size,
  input  logic [1:0]        cfg_perm,
  input  logic              cfg_enable,
  input  logic              ctl_we,
  input  logic              ctl_bg_en,
  input  logic              acc_valid,
  input  logic [31:0]       acc_addr,
  input  logic              acc_write,
  input  logic              acc_priv,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic              rsp_fault,
  output logic [1:0]        rsp_cause,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_region,
  output logic [31:0]       rsp_fault_addr
);
  region_t                   cfg_word;
  region_t [NUM_REGIONS-1:0] regions;
  logic [NUM_REGIONS-1:0]    hit_vec, allow_vec;
  logic                      any_hit;
  logic [IDX_W-1:0]          win_idx;
  logic                      bg_en_q;
  logic                      win_allow, bg_grant, grant_c;
  cause_e                    cause_c;

  assign cfg_word = '{base: cfg_base, size: cfg_size, perm: perm_e'(cfg_perm), en: cfg_enable};

  mpu_region_bank #(.NUM_REGIONS(NUM_REGIONS)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_word), .regions(regions)
  );

  mpu_region_match #(.NUM_REGIONS(NUM_REGIONS)) u_match (
    .regions(regions), .addr(acc_addr), .wr(acc_write), .priv(acc_priv),
    .hit_vec(hit_vec), .allow_vec(allow_vec)
  );

  mpu_prio_select #(.NUM_REGIONS(NUM_REGIONS)) u_prio (
    .hit_vec(hit_vec), .any_hit(any_hit), .win_idx(win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bg_en_q <= 1'b0;
    else if (ctl_we) bg_en_q <= ctl_bg_en;
  end

  assign win_allow = allow_vec[win_idx];
  assign bg_grant  = acc_priv & bg_en_q;
  assign grant_c   = any_hit ? win_allow : bg_grant;

  always_comb begin
    if (grant_c)      cause_c = CAUSE_NONE;
    else if (any_hit) cause_c = CAUSE_PERM;
    else              cause_c = CAUSE_NOMATCH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_grant      <= 1'b0;
      rsp_fault      <= 1'b0;
      rsp_cause      <= 2'd0;
      rsp_hit        <= 1'b0;
      rsp_region     <= '0;
      rsp_fault_addr <= '0;
    end else begin
      rsp_valid      <= acc_valid;
      rsp_grant      <= acc_valid & grant_c;
      rsp_fault      <= acc_valid & ~grant_c;
      rsp_cause      <= acc_valid ? cause_c : CAUSE_NONE;
      rsp_hit        <= acc_valid & any_hit;
      rsp_region     <= (acc_valid && any_hit) ? win_idx : '0;
      rsp_fault_addr <= (acc_valid && !grant_c) ? acc_addr : '0;
    end
  end
endmodule

// File: rtl/mpu_region_check_sva.sv
module mpu_region_check_sva #(
  parameter int IDX_W = 3
)(
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic [31:0]      acc_addr,
  input logic             acc_priv,
  input logic             bg_en,
  input logic             rsp_valid,
  input logic             rsp_grant,
  input logic             rsp_fault,
  input logic [1:0]       rsp_cause,
  input logic             rsp_hit,
  input logic [IDX_W-1:0] rsp_region,
  input logic [31:0]      rsp_fault_addr
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_grant, rsp_fault}) == 1); // R10
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_grant && !rsp_fault); // R8
  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (rsp_fault ? rsp_fault_addr == $past(acc_addr) : rsp_fault_addr == 32'd0)); // R8
  AST_CAUSE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_grant |-> rsp_cause == 2'd0); // R6
  AST_CAUSE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_cause == 2'd1 || rsp_cause == 2'd2)); // R6
  AST_NOMATCH_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault && rsp_cause == 2'd1) |-> !rsp_hit && rsp_region == '0); // R6
  AST_BG_PRIV_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_priv |=> !(rsp_grant && !rsp_hit)); // R7
  AST_BG_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !bg_en |=> !(rsp_grant && !rsp_hit)); // R7
endmodule

bind mpu_region_check mpu_region_check_sva #(.IDX_W(IDX_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_priv(acc_priv), .bg_en(bg_en_q), .rsp_valid(rsp_valid),
  .rsp_grant(rsp_grant), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
  .rsp_hit(rsp_hit), .rsp_region(rsp_region), .rsp_fault_addr(rsp_fault_addr)
);

// File: tb/mpu_region_check_test.sv
module mpu_region_check_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_enable = 0, ctl_we = 0, ctl_bg_en = 0;
  logic [2:0] cfg_sel = 0;
  logic [31:0] cfg_base = 0;
  logic [4:0] cfg_size = 0;
  logic [1:0] cfg_perm = 0;
  logic acc_valid = 0, acc_write = 0, acc_priv = 0;
  logic [31:0] acc_addr = 0;
  logic rsp_valid, rsp_grant, rsp_fault, rsp_hit;
  logic [1:0] rsp_cause;
  logic [2:0] rsp_region;
  logic [31:0] rsp_fault_addr;

  int checks = 0, fails = 0;
  logic [31:0] m_base [8];
  logic [4:0]  m_size [8];
  logic [1:0]  m_perm [8];
  logic        m_en   [8];
  logic        m_bg = 0;

  always #4 clk = ~clk;

  mpu_region_check uut (.*);

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic logic covers(input logic [31:0] a, input int i);
    logic [63:0] s;
    if (!m_en[i] || m_size[i] < 5'd4) return 1'b0;
    s = 64'(m_size[i]) + 64'd1;
    return (64'(a) >> s) == (64'(m_base[i]) >> s);
  endfunction

  function automatic logic may(input logic [1:0] p, input logic w, input logic pv);
    if (p == 2'd3) return 1'b1;
    if (p == 2'd2) return pv || !w;
    if (p == 2'd1) return pv;
    return 1'b0;
  endfunction

  // expected {grant, cause, hit, region}
  function automatic logic [6:0] predict(input logic [31:0] a, input logic w, input logic pv);
    for (int i = 7; i >= 0; i--)
      if (covers(a, i)) begin
        if (may(m_perm[i], w, pv)) return {1'b1, 2'd0, 1'b1, 3'(i)};
        return {1'b0, 2'd2, 1'b1, 3'(i)};
      end
    if (m_bg && pv) return {1'b1, 2'd0, 1'b0, 3'd0};
    return {1'b0, 2'd1, 1'b0, 3'd0};
  endfunction

  task automatic set_region(input int i, input logic [31:0] b, input logic [4:0] s,
                            input logic [1:0] p, input logic e);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(i); cfg_base = b; cfg_size = s; cfg_perm = p; cfg_enable = e;
    m_base[i] = b; m_size[i] = s; m_perm[i] = p; m_en[i] = e;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_bg(input logic v);
    @(negedge clk);
    ctl_we = 1; ctl_bg_en = v; m_bg = v;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic access(input logic [31:0] a, input logic w, input logic pv, input string req);
    logic [6:0] e;
    logic [31:0] ea;
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_write = w; acc_priv = pv;
    e = predict(a, w, pv);
    ea = e[6] ? 32'd0 : a;
    @(negedge clk);
    acc_valid = 0;
    checks++;
    if (rsp_valid !== 1'b1 || rsp_grant !== e[6] || rsp_fault !== !e[6] ||
        rsp_cause !== e[5:4] || rsp_hit !== e[3] || rsp_region !== e[2:0] ||
        rsp_fault_addr !== ea) begin
      fails++;
      $display("FAIL %s addr=%h w=%0b p=%0b actual g=%0b c=%0d h=%0b r=%0d fa=%h expected g=%0b c=%0d h=%0b r=%0d fa=%h",
               req, a, w, pv, rsp_grant, rsp_cause, rsp_hit, rsp_region, rsp_fault_addr,
               e[6], e[5:4], e[3], e[2:0], ea);
    end
  endtask

  task automatic expect_idle(input string req);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_grant !== 0 || rsp_fault !== 0 || rsp_cause !== 0 ||
        rsp_hit !== 0 || rsp_region !== 0 || rsp_fault_addr !== 0) begin
      fails++;
      $display("FAIL %s idle outputs actual v=%0b g=%0b f=%0b c=%0d expected all zero",
               req, rsp_valid, rsp_grant, rsp_fault, rsp_cause);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_base[i] = 0; m_size[i] = 0; m_perm[i] = 0; m_en[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_idle("R1 reset");
    access(32'h1234_5678, 1'b0, 1'b1, "R1 empty table");
    // R2 size and alignment
    set_region(0, 32'h2000_0123, 5'd9, 2'd3, 1'b1);
    access(32'h2000_03FC, 1'b1, 1'b0, "R2 inside 1KB");
    access(32'h2000_0400, 1'b1, 1'b0, "R2 past end");
    access(32'h1FFF_FFFF, 1'b0, 1'b0, "R2 before start");
    set_region(1, 32'h3000_0000, 5'd3, 2'd3, 1'b1);
    access(32'h3000_0000, 1'b0, 1'b1, "R2 size code 3 disabled");
    set_region(1, 32'h3000_0020, 5'd4, 2'd3, 1'b1);
    access(32'h3000_003F, 1'b0, 1'b1, "R2 32B top");
    access(32'h3000_0040, 1'b0, 1'b1, "R2 32B past");
    access(32'h3000_001F, 1'b0, 1'b1, "R2 32B below");
    // R3 whole space
    set_region(2, 32'hDEAD_BEEF, 5'd31, 2'd1, 1'b1);
    access(32'h4000_0000, 1'b0, 1'b0, "R3 whole space unpriv");
    access(32'hFFFF_FFFF, 1'b1, 1'b1, "R3 whole space priv");
    // R4 overlap priority
    access(32'h2000_0010, 1'b1, 1'b0, "R4 region2 over region0");
    set_region(5, 32'h2000_0000, 5'd9, 2'd3, 1'b1);
    access(32'h2000_0010, 1'b1, 1'b0, "R4 region5 over region2");
    // R5 permission matrix on region 7
    for (int p = 0; p < 4; p++) begin
      set_region(7, 32'h5000_0000, 5'd11, 2'(p), 1'b1);
      for (int k = 0; k < 4; k++)
        access(32'h5000_0800, k[0], k[1], "R5 perm matrix");
    end
    // R9 enable clear
    set_region(7, 32'h5000_0000, 5'd11, 2'd0, 1'b0);
    access(32'h5000_0800, 1'b0, 1'b1, "R9 disabled region ignored");
    // R6 / R7 background
    set_region(2, 32'h0, 5'd31, 2'd3, 1'b0);
    access(32'h4000_0000, 1'b0, 1'b1, "R6 no match cause");
    set_bg(1'b1);
    access(32'h4000_0000, 1'b1, 1'b1, "R7 background priv");
    access(32'h4000_0000, 1'b0, 1'b0, "R7 background unpriv");
    access(32'h2000_0000, 1'b1, 1'b0, "R7 region still decides");
    // R8 no access -> quiet
    expect_idle("R8 idle");
    // random mix, fixed seed
    begin
      int unsigned seed;
      logic [31:0] a;
      seed = $urandom(32'd715);
      for (int n = 0; n < 3000; n++) begin
        if ($urandom_range(9) == 0) begin
          int r;
          r = $urandom_range(7);
          set_region(r, $urandom, 5'($urandom_range(31)), 2'($urandom_range(3)),
                     1'($urandom_range(4) != 0));
        end else if ($urandom_range(60) == 0) begin
          set_bg(1'($urandom_range(1)));
        end else begin
          int r;
          r = $urandom_range(7);
          a = ($urandom_range(1) != 0) ? (m_base[r] + 32'($urandom_range(63)) - 32'd16) : $urandom;
          access(a, 1'($urandom_range(1)), 1'($urandom_range(1)), "R10 random R4 R5 R6");
        end
      end
      if (seed == 0) $display("seed zero");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule